// File: doc/BRIEF.md
# Configurable parallel-to-serial transmitter

This block converts parallel words into a single serial bit stream. Configuration inputs choose the word width (ten bits, or eight bits), the bit rate (full, half or quarter), the output polarity and whether the transmitter runs. The block also produces a word-rate clock. The data source uses this clock to pace its words. While a word is being sent, the source presents the next word, and the block loads it on the bit slot right after the last bit of the current word.

Everything runs on one fast clock at the full-rate bit rate. Lower rates are made with slot enables, so that half rate holds each bit for two clocks and quarter rate for four. The configuration inputs are registered once inside the block. Width and rate changes are adopted only at word boundaries. Reserved codes stop the transmitter at once and raise an error flag. The serial output is a complementary pair.

Top module: `ser_tx`

## Requirements
- R1: After reset, ser_p is 0, ser_n is 1, word_clk is 0 and cfg_err is 0. Every configuration field resets to zero, which means ten-bit width, full rate, normal polarity and disabled.
- R2: With width code 3'b000, each word is sent least significant bit first, word_i[0] through word_i[9]. Words follow one another with no gap.
- R3: With width code 3'b001, word_i[2] through word_i[9] are sent in that order, and word_i[1:0] have no effect on the output.
- R4: In ten-bit mode, word_clk is high during the first 4 bit slots of each word and low during the remaining 6.
- R5: In eight-bit mode, word_clk is high during the first 4 bit slots and low during the last 4.
- R6: Rate code 2'b00 holds each bit for 1 clock, 2'b01 holds it for 2 clocks and 2'b10 holds it for 4 clocks.
- R7: When cfg_invert is 1, ser_p carries the inverted bit. ser_n is always the complement of ser_p.
- R8: While cfg_enable is 0, word_clk is 0 and ser_p equals cfg_invert. The configuration inputs are registered once, so after enable rises the first bit (slot 0 of the word on word_i) appears two clock edges later.
- R9: A width code of 3'b010, 3'b011 or 3'b1xx, or a rate code of 2'b11, sets cfg_err one edge after it is applied. From the second edge on, the outputs are quiet as in R8 until a legal code is restored, and the transmitter then restarts at slot 0.
- R10: A width or rate change made in the middle of a word leaves that word at its old width and rate. The next word uses the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Transmitter run enable |
| cfg_width | input | 3 | Word width code |
| cfg_rate | input | 2 | Bit rate code |
| cfg_invert | input | 1 | Output polarity inversion |
| word_i | input | 10 | Parallel word from the source |
| ser_p | output | 1 | Serial data, true leg |
| ser_n | output | 1 | Serial data, complement leg |
| word_clk | output | 1 | Word-rate clock for the source |
| cfg_err | output | 1 | Reserved configuration code present |

## Verification
A width or rate change can land in the same cycle as the load of the next word. That load is exactly the moment the new mode is adopted. The bench provokes this collision by changing the mode while the second-to-last bit is visible at full rate, so the registered setting is already new during the final slot. It also changes the mode early in a word. In both cases, every clock of the ongoing word is compared against the old width and rate, and every clock of the following word against the new ones.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef struct packed {
    logic       en;
    logic [2:0] wid;
    logic [1:0] rate;
    logic       inv;
  } cfg_t;

  function automatic logic wid_reserved(input logic [2:0] w);
    return w[2] | w[1];
  endfunction

  function automatic logic rate_reserved(input logic [1:0] r);
    return r[1] & r[0];
  endfunction

endpackage

// File: rtl/ser_tx_pace.sv
module ser_tx_pace #(
  parameter int DIV_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr,
  input  logic [1:0] rate,
  output logic       slot_end
);
  logic [DIV_W-1:0] div_q, div_d, lim;

  always_comb begin
    case (rate)
      2'b00:   lim = DIV_W'(0);
      2'b01:   lim = DIV_W'(1);
      default: lim = DIV_W'(3);
    endcase
  end

  always_comb begin
    slot_end = !clr && (div_q == lim);
    if (clr || div_q == lim) div_d = '0;
    else                     div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq #(
  parameter int DATA_W     = 10,
  parameter int NARROW_W   = 8,
  parameter int HIGH_SLOTS = 4,
  parameter int IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             slot_end,
  input  logic             narrow_cfg,
  input  logic [1:0]       rate_cfg,
  output logic             running,
  output logic             load,
  output logic             shift,
  output logic             narrow_act,
  output logic [1:0]       rate_act,
  output logic             wclk,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_W - 1);
  localparam logic [IDX_W-1:0] HIGH_LIM    = IDX_W'(HIGH_SLOTS);

  logic             run_q, run_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             nar_q, nar_d;
  logic [1:0]       rate_q, rate_d;
  logic             last;

  always_comb begin
    last  = idx_q == (nar_q ? LAST_NARROW : LAST_WIDE);
    load  = run && (!run_q || (slot_end && last));
    shift = run && run_q && slot_end && !last;
    run_d  = run;
    nar_d  = load ? narrow_cfg : nar_q;
    rate_d = load ? rate_cfg : rate_q;
    if (!run || load) idx_d = '0;
    else if (shift)   idx_d = idx_q + IDX_W'(1);
    else              idx_d = idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      nar_q  <= 1'b0;
      rate_q <= 2'b00;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      nar_q  <= nar_d;
      rate_q <= rate_d;
    end
  end

  assign running    = run_q;
  assign narrow_act = nar_q;
  assign rate_act   = rate_q;
  assign idx        = idx_q;
  assign wclk       = run_q && (idx_q < HIGH_LIM);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int DATA_W   = 10,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr,
  input  logic              load,
  input  logic              shift,
  input  logic              narrow,
  input  logic [DATA_W-1:0] word_i,
  output logic              bit_o
);
  localparam int SKIP = DATA_W - NARROW_W;

  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    if (clr)        sh_d = '0;
    else if (load)  sh_d = narrow ? (word_i >> SKIP) : word_i;
    else if (shift) sh_d = sh_q >> 1;
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int DATA_W     = 10,
  parameter int NARROW_W   = 8,
  parameter int HIGH_SLOTS = 4,
  parameter int DIV_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_enable,
  input  logic [2:0]        cfg_width,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_invert,
  input  logic [DATA_W-1:0] word_i,
  output logic              ser_p,
  output logic              ser_n,
  output logic              word_clk,
  output logic              cfg_err
);
  import ser_tx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  cfg_t             cfg_q, cfg_d;
  logic             run, running, load, shift, slot_end;
  logic             narrow_act, sh_bit;
  logic [1:0]       rate_act;
  logic [IDX_W-1:0] idx;

  always_comb begin
    cfg_d.en   = cfg_enable;
    cfg_d.wid  = cfg_width;
    cfg_d.rate = cfg_rate;
    cfg_d.inv  = cfg_invert;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_err = wid_reserved(cfg_q.wid) | rate_reserved(cfg_q.rate);
  assign run     = cfg_q.en && !cfg_err;

  ser_tx_pace #(.DIV_W(DIV_W)) u_pace (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr(!running),
    .rate(rate_act), .slot_end(slot_end)
  );

  ser_tx_seq #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W),
    .HIGH_SLOTS(HIGH_SLOTS), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .slot_end(slot_end),
    .narrow_cfg(cfg_q.wid[0]), .rate_cfg(cfg_q.rate),
    .running(running), .load(load), .shift(shift),
    .narrow_act(narrow_act), .rate_act(rate_act),
    .wclk(word_clk), .idx(idx)
  );

  ser_tx_shift #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr(!run), .load(load),
    .shift(shift), .narrow(cfg_q.wid[0]), .word_i(word_i), .bit_o(sh_bit)
  );

  assign ser_p = (sh_bit & running) ^ cfg_q.inv;
  assign ser_n = ~ser_p;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
  parameter int DATA_W   = 10,
  parameter int NARROW_W = 8,
  parameter int IDX_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_clk,
  input logic             cfg_err,
  input logic             running,
  input logic             slot_end,
  input logic             load,
  input logic             narrow_act,
  input logic [1:0]       rate_act,
  input logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LEN_WIDE   = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] LEN_NARROW = IDX_W'(NARROW_W);

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err |=> !word_clk);  // R9
  AST_WCLK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_clk) |-> (idx == '0));  // R4
  AST_IDX_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> (idx < (narrow_act ? LEN_NARROW : LEN_WIDE)));  // R3
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !load) |=> ($stable(narrow_act) && $stable(rate_act)));  // R10
  AST_FULL_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && rate_act == 2'b00) |-> slot_end);  // R6
endmodule

bind ser_tx ser_tx_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_clk(word_clk), .cfg_err(cfg_err),
  .running(running), .slot_end(slot_end), .load(load),
  .narrow_act(narrow_act), .rate_act(rate_act), .idx(idx)
);

// File: tb/ser_tx_test.sv
module ser_tx_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_enable;
  logic [2:0] cfg_width;
  logic [1:0] cfg_rate;
  logic       cfg_invert;
  logic [9:0] word_i;
  logic       ser_p, ser_n, word_clk, cfg_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ser_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_enable(cfg_enable),
    .cfg_width(cfg_width), .cfg_rate(cfg_rate), .cfg_invert(cfg_invert),
    .word_i(word_i), .ser_p(ser_p), .ser_n(ser_n),
    .word_clk(word_clk), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet_check(input string tag);
    check(word_clk == 1'b0, tag, word_clk, 0);
    check(ser_p == cfg_invert, tag, ser_p, cfg_invert);
    check(ser_n == ~cfg_invert, tag, ser_n, !cfg_invert);
  endtask

  task automatic start_tx(input [2:0] w, input [1:0] r, input bit inv, input [9:0] d);
    @(negedge clk_i);
    cfg_width = w; cfg_rate = r; cfg_invert = inv; word_i = d; cfg_enable = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic stop_tx(input string tag);
    @(negedge clk_i);
    cfg_enable = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    for (int k = 0; k < 6; k++) begin
      quiet_check(tag);
      @(negedge clk_i);
    end
  endtask

  // Entered at the negedge where slot 0 of cur is visible; leaves at slot 0 of the next word.
  task automatic send_word(input [9:0] cur, input [9:0] nxt, input [2:0] w, input [1:0] r,
                           input bit inv, input int chg_at, input [2:0] nw, input [1:0] nr,
                           input string tag);
    int len  = (w == 3'b000) ? 10 : 8;
    int per  = 1 << r;
    int base = (w == 3'b000) ? 0 : 2;
    for (int i = 0; i < len; i++) begin
      for (int j = 0; j < per; j++) begin
        logic e = cur[base + i] ^ inv;
        check(ser_p == e, tag, ser_p, e);
        check(ser_n == ~e, tag, ser_n, !e);
        check(word_clk == (i < 4), tag, word_clk, int'(i < 4));
        if (i == 0 && j == 0) word_i = nxt;
        if (i == chg_at && j == 0) begin cfg_width = nw; cfg_rate = nr; end
        @(negedge clk_i);
      end
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; cfg_enable = 1'b0; cfg_width = 3'b000; cfg_rate = 2'b00;
    cfg_invert = 1'b0; word_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(ser_p == 1'b0, "R1", ser_p, 0);
    check(ser_n == 1'b1, "R1", ser_n, 1);
    check(word_clk == 1'b0, "R1", word_clk, 0);
    check(cfg_err == 1'b0, "R1", cfg_err, 0);
  endtask

  task automatic t_wide_full;
    start_tx(3'b000, 2'b00, 1'b0, 10'h2D3);
    send_word(10'h2D3, 10'h1A5, 3'b000, 2'b00, 1'b0, -1, 3'b000, 2'b00, "R2 R4");
    send_word(10'h1A5, 10'h3FF, 3'b000, 2'b00, 1'b0, -1, 3'b000, 2'b00, "R2 R4");
    send_word(10'h3FF, 10'h000, 3'b000, 2'b00, 1'b0, -1, 3'b000, 2'b00, "R2 R4");
    stop_tx("R8");
  endtask

  task automatic t_narrow;
    start_tx(3'b001, 2'b00, 1'b0, 10'h2B7);
    send_word(10'h2B7, 10'h148, 3'b001, 2'b00, 1'b0, -1, 3'b001, 2'b00, "R3 R5");
    send_word(10'h148, 10'h0F2, 3'b001, 2'b00, 1'b0, -1, 3'b001, 2'b00, "R3 R5");
    send_word(10'h0F2, 10'h000, 3'b001, 2'b00, 1'b0, -1, 3'b001, 2'b00, "R3 R5");
    stop_tx("R8");
  endtask

  task automatic t_rates;
    start_tx(3'b000, 2'b01, 1'b0, 10'h35A);
    send_word(10'h35A, 10'h0C9, 3'b000, 2'b01, 1'b0, -1, 3'b000, 2'b01, "R6 half");
    send_word(10'h0C9, 10'h000, 3'b000, 2'b01, 1'b0, -1, 3'b000, 2'b01, "R6 half");
    stop_tx("R8");
    start_tx(3'b001, 2'b10, 1'b0, 10'h26D);
    send_word(10'h26D, 10'h193, 3'b001, 2'b10, 1'b0, -1, 3'b001, 2'b10, "R6 quarter");
    send_word(10'h193, 10'h000, 3'b001, 2'b10, 1'b0, -1, 3'b001, 2'b10, "R6 quarter");
    stop_tx("R8");
  endtask

  task automatic t_invert;
    start_tx(3'b000, 2'b00, 1'b1, 10'h0E1);
    send_word(10'h0E1, 10'h31C, 3'b000, 2'b00, 1'b1, -1, 3'b000, 2'b00, "R7");
    send_word(10'h31C, 10'h000, 3'b000, 2'b00, 1'b1, -1, 3'b000, 2'b00, "R7");
    stop_tx("R7 R8");
    @(negedge clk_i); cfg_invert = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    quiet_check("R8");
  endtask

  task automatic t_restart;
    start_tx(3'b000, 2'b00, 1'b0, 10'h15B);
    send_word(10'h15B, 10'h2A4, 3'b000, 2'b00, 1'b0, 3, 3'b000, 2'b00, "R2");
    @(negedge clk_i); cfg_enable = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    quiet_check("R8");
    // re-enable mid-stream: restart at slot 0 of the word on word_i
    start_tx(3'b000, 2'b00, 1'b0, 10'h2A4);
    send_word(10'h2A4, 10'h000, 3'b000, 2'b00, 1'b0, -1, 3'b000, 2'b00, "R8 restart");
    stop_tx("R8");
  endtask

  task automatic reserved_one(input [2:0] w, input [1:0] r, input string tag);
    start_tx(3'b000, 2'b00, 1'b0, 10'h3C5);
    send_word(10'h3C5, 10'h3C5, 3'b000, 2'b00, 1'b0, -1, 3'b000, 2'b00, "R2");
    @(negedge clk_i); cfg_width = w; cfg_rate = r;
    @(posedge clk_i); @(negedge clk_i);
    check(cfg_err == 1'b1, tag, cfg_err, 1);
    @(posedge clk_i); @(negedge clk_i);
    for (int k = 0; k < 5; k++) begin
      quiet_check(tag);
      check(cfg_err == 1'b1, tag, cfg_err, 1);
      @(negedge clk_i);
    end
    cfg_width = 3'b000; cfg_rate = 2'b00;
    @(posedge clk_i); @(negedge clk_i);
    check(cfg_err == 1'b0, tag, cfg_err, 0);
    @(posedge clk_i); @(negedge clk_i);
    send_word(10'h3C5, 10'h000, 3'b000, 2'b00, 1'b0, -1, 3'b000, 2'b00, "R9 restart");
    stop_tx("R8");
  endtask

  task automatic t_reserved;
    reserved_one(3'b010, 2'b00, "R9 width 010");
    reserved_one(3'b011, 2'b00, "R9 width 011");
    reserved_one(3'b100, 2'b00, "R9 width 100");
    reserved_one(3'b000, 2'b11, "R9 rate 11");
  endtask

  task automatic t_boundary;
    start_tx(3'b000, 2'b00, 1'b0, 10'h1E6);
    // change lands so the registered mode is new during the final slot
    send_word(10'h1E6, 10'h2D9, 3'b000, 2'b00, 1'b0, 8, 3'b001, 2'b01, "R10 late");
    // change early in a word
    send_word(10'h2D9, 10'h0B7, 3'b001, 2'b01, 1'b0, 1, 3'b000, 2'b10, "R10 early");
    send_word(10'h0B7, 10'h000, 3'b000, 2'b10, 1'b0, -1, 3'b000, 2'b10, "R10 new");
    stop_tx("R8");
  endtask

  initial begin
    t_reset();
    t_wide_full();
    t_narrow();
    t_rates();
    t_invert();
    t_restart();
    t_reserved();
    t_boundary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule